// File: doc/BRIEF.md
# Internal Burst Trigger Generator

This block produces the trigger events that start each delay cycle of a delay generator when no external trigger source is used. It has two modes. In burst mode a start strobe begins a programmable wait and then releases a programmed number of triggers at a fixed spacing. In continuous mode it keeps issuing triggers at that spacing for as long as it stays enabled. Each trigger is a single-cycle pulse. A busy flag is high from the accepted start until the sequence ends.

Spacing and start delay are counted in clock cycles. At a 100 MHz clock one cycle is 10 ns, so the default 32-bit period input covers 100 ns to about 42.9 s. The period, count, delay and mode inputs are captured at the accepted start. Later changes take effect only at the next start. The sequencer has four states: `ST_IDLE`, `ST_START_DELAY`, `ST_FIRE` and `ST_WAIT_PERIOD`. These are its transitions:

- **go**: IDLE to START_DELAY, on start with enable high.
- **delay_done**: START_DELAY to FIRE, when the delay timer reaches zero.
- **rearm**: FIRE to WAIT_PERIOD, when more triggers are due.
- **period_done**: WAIT_PERIOD to FIRE, when the period timer reaches zero.
- **burst_done**: FIRE to IDLE, after the last trigger of a burst.
- **abort**: any busy state to IDLE, when enable is low.

Top module: `burst_trig_gen`

## Requirements
- R1: After reset `trig_o` and `busy_o` are low.
- R2: If `start_i` is high with `enable_i` high while idle, and it is sampled at clock edge n, then `busy_o` is high from edge n. The first trigger is high in the cycle after edge n+D+1, where D is `first_delay_i` (D = 0 allowed).
- R3: `trig_o` is high for exactly one clock cycle per trigger.
- R4: In burst mode (`cont_mode_i` = 0) the block issues exactly N = `burst_len_i` triggers, spaced P = `period_i` cycles apart. `busy_o` falls on the edge after the last trigger.
- R5: A burst length of 0 produces exactly one trigger.
- R6: A period below MIN_PERIOD (default 10 cycles) is used as MIN_PERIOD. Triggers are never closer than MIN_PERIOD cycles.
- R7: In continuous mode (`cont_mode_i` = 1) triggers repeat every P cycles without end, and `burst_len_i` is ignored.
- R8: If `enable_i` is sampled low at edge m, the block is idle from edge m (`busy_o` low), and no trigger follows.
- R9: A start strobe received while busy is ignored. The trigger schedule is unchanged.
- R10: A start strobe while `enable_i` is low is ignored. `busy_o` stays low and no trigger occurs.
- R11: Period, length, delay and mode are captured at the accepted start. Changes while busy do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Enable; low aborts any sequence |
| cont_mode_i | input | 1 | 1 = continuous, 0 = burst |
| start_i | input | 1 | Start strobe |
| period_i | input | PERIOD_W | Trigger spacing in cycles |
| burst_len_i | input | BURST_W | Triggers per burst |
| first_delay_i | input | DELAY_W | Cycles from start to first trigger |
| trig_o | output | 1 | One-cycle trigger pulse |
| busy_o | output | 1 | Sequence in progress |

## Verification
The bench checks the exact cycle of every trigger against a schedule built from the start edge. This catches an off-by-one in either timer, which would shift every pulse by one cycle.

It drives a zero delay, a zero burst length and a period below the minimum. A design that skipped normalising these would fire at once, fire 2^32 - 1 times, or fire faster than 10 MHz.

It pulses start and changes the configuration in the middle of a burst. A design that re-armed on that start or read the live inputs would move later pulses.

It drops enable during a start delay and during a continuous run. A design that ignored enable, or let one more pulse out after it fell, would fire an unexpected trigger.

// File: rtl/burst_trig_pkg.sv
package burst_trig_pkg;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_START_DELAY = 2'd1,
        ST_FIRE        = 2'd2,
        ST_WAIT_PERIOD = 2'd3
    } seq_state_e;

    typedef enum logic {
        MODE_BURST = 1'b0,
        MODE_CONT  = 1'b1
    } seq_mode_e;

endpackage

// File: rtl/burst_trig_cfg.sv
// Normalises and captures the sequence configuration on an accepted start.
module burst_trig_cfg #(
    parameter int PERIOD_W   = 32,
    parameter int BURST_W    = 32,
    parameter int MIN_PERIOD = 10
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                capture_i,
    input  logic                cont_mode_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic [BURST_W-1:0]  burst_len_i,
    output logic [BURST_W-1:0]  burst_len_norm_o,
    output logic [PERIOD_W-1:0] period_lat_o,
    output burst_trig_pkg::seq_mode_e mode_lat_o
);
    import burst_trig_pkg::*;

    // The period reload subtracts two, so the floor is at least two cycles.
    localparam int FLOOR = (MIN_PERIOD < 2) ? 2 : MIN_PERIOD;
    localparam logic [PERIOD_W-1:0] FLOOR_V = PERIOD_W'(FLOOR);

    logic [PERIOD_W-1:0] period_eff;

    generate
        if (MIN_PERIOD > 2) begin : g_rate_clamp
            assign period_eff = (period_i < FLOOR_V) ? FLOOR_V : period_i;
        end else begin : g_min_clamp
            assign period_eff = (period_i < 2) ? PERIOD_W'(2) : period_i;
        end
    endgenerate

    // A zero length counts as a single trigger.
    assign burst_len_norm_o = (burst_len_i == '0) ? BURST_W'(1) : burst_len_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            period_lat_o <= FLOOR_V;
            mode_lat_o   <= MODE_BURST;
        end else if (capture_i) begin
            period_lat_o <= period_eff;
            mode_lat_o   <= cont_mode_i ? MODE_CONT : MODE_BURST;
        end
    end

endmodule

// File: rtl/burst_trig_timer.sv
// Loadable down-counter shared by the start delay and the period wait.
module burst_trig_timer #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         run_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/burst_trig_count.sv
// Counts the triggers still owed in a burst.
module burst_trig_count #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic         last_o
);
    logic [W-1:0] rem_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= load_val_i;
        end else if (dec_i && (rem_q != '0)) begin
            rem_q <= rem_q - W'(1);
        end
    end

    assign last_o = (rem_q == W'(1));

endmodule

// File: rtl/burst_trig_fsm.sv
// Sequencer: state register, next-state logic and output decode.
module burst_trig_fsm (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      enable_i,
    input  logic                      start_i,
    input  burst_trig_pkg::seq_mode_e mode_i,
    input  logic                      tmr_zero_i,
    input  logic                      burst_last_i,
    output logic                      capture_o,
    output logic                      tmr_load_delay_o,
    output logic                      tmr_load_period_o,
    output logic                      tmr_run_o,
    output logic                      cnt_dec_o,
    output logic                      trig_o,
    output logic                      busy_o
);
    import burst_trig_pkg::*;

    seq_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable_i && start_i) state_d = ST_START_DELAY;   // go
            end
            ST_START_DELAY: begin
                if (!enable_i)       state_d = ST_IDLE;              // abort
                else if (tmr_zero_i) state_d = ST_FIRE;              // delay_done
            end
            ST_FIRE: begin
                if (!enable_i)
                    state_d = ST_IDLE;                               // abort
                else if ((mode_i == MODE_BURST) && burst_last_i)
                    state_d = ST_IDLE;                               // burst_done
                else
                    state_d = ST_WAIT_PERIOD;                        // rearm
            end
            ST_WAIT_PERIOD: begin
                if (!enable_i)       state_d = ST_IDLE;              // abort
                else if (tmr_zero_i) state_d = ST_FIRE;              // period_done
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture_o         = 1'b0;
        tmr_load_delay_o  = 1'b0;
        tmr_load_period_o = 1'b0;
        tmr_run_o         = 1'b0;
        cnt_dec_o         = 1'b0;
        trig_o            = 1'b0;
        busy_o            = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o           = 1'b0;
                capture_o        = enable_i && start_i;
                tmr_load_delay_o = enable_i && start_i;
            end
            ST_START_DELAY: tmr_run_o = 1'b1;
            ST_FIRE: begin
                trig_o            = 1'b1;
                tmr_load_period_o = 1'b1;
                cnt_dec_o         = 1'b1;
            end
            ST_WAIT_PERIOD: tmr_run_o = 1'b1;
            default: busy_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/burst_trig_gen.sv
// Top level: internal trigger generator with burst and continuous modes.
module burst_trig_gen #(
    parameter int PERIOD_W   = 32,
    parameter int BURST_W    = 32,
    parameter int DELAY_W    = 32,
    parameter int MIN_PERIOD = 10
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                enable_i,
    input  logic                cont_mode_i,
    input  logic                start_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic [BURST_W-1:0]  burst_len_i,
    input  logic [DELAY_W-1:0]  first_delay_i,
    output logic                trig_o,
    output logic                busy_o
);
    import burst_trig_pkg::*;

    localparam int TMR_W = (DELAY_W > PERIOD_W) ? DELAY_W : PERIOD_W;

    logic                capture, tmr_load_delay, tmr_load_period, tmr_run;
    logic                cnt_dec, tmr_zero, burst_last;
    logic [BURST_W-1:0]  burst_len_norm;
    logic [PERIOD_W-1:0] period_lat;
    seq_mode_e           mode_lat;
    logic [TMR_W-1:0]    tmr_val;

    burst_trig_cfg #(
        .PERIOD_W  (PERIOD_W),
        .BURST_W   (BURST_W),
        .MIN_PERIOD(MIN_PERIOD)
    ) cfg_i (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .capture_i       (capture),
        .cont_mode_i     (cont_mode_i),
        .period_i        (period_i),
        .burst_len_i     (burst_len_i),
        .burst_len_norm_o(burst_len_norm),
        .period_lat_o    (period_lat),
        .mode_lat_o      (mode_lat)
    );

    // The FIRE cycle plus (P-2)+1 wait cycles make up one period.
    always_comb begin
        if (tmr_load_delay) tmr_val = TMR_W'(first_delay_i);
        else                tmr_val = TMR_W'(period_lat - PERIOD_W'(2));
    end

    burst_trig_timer #(.W(TMR_W)) tmr_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (tmr_load_delay | tmr_load_period),
        .load_val_i(tmr_val),
        .run_i     (tmr_run),
        .zero_o    (tmr_zero)
    );

    burst_trig_count #(.W(BURST_W)) cnt_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (capture),
        .load_val_i(burst_len_norm),
        .dec_i     (cnt_dec),
        .last_o    (burst_last)
    );

    burst_trig_fsm fsm_i (
        .clk_i            (clk_i),
        .rst_ni           (rst_ni),
        .enable_i         (enable_i),
        .start_i          (start_i),
        .mode_i           (mode_lat),
        .tmr_zero_i       (tmr_zero),
        .burst_last_i     (burst_last),
        .capture_o        (capture),
        .tmr_load_delay_o (tmr_load_delay),
        .tmr_load_period_o(tmr_load_period),
        .tmr_run_o        (tmr_run),
        .cnt_dec_o        (cnt_dec),
        .trig_o           (trig_o),
        .busy_o           (busy_o)
    );

endmodule

// File: rtl/burst_trig_gen_chk.sv
module burst_trig_gen_chk #(
    parameter int MIN_PERIOD = 10
) (
    input logic clk_i,
    input logic rst_ni,
    input logic enable_i,
    input logic start_i,
    input logic trig_o,
    input logic busy_o
);
    logic [31:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (trig_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            if (!busy_o) seen_q <= 1'b0;
            if (gap_q != 32'hFFFF_FFFF) gap_q <= gap_q + 32'd1;
        end
    end

    // R3
    trig_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |=> !trig_o);

    // R2
    trig_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |-> busy_o);

    // R8
    enable_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (!busy_o && !trig_o));

    // R10
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !(start_i && enable_i)) |=> !busy_o);

    // R6
    min_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_o && seen_q) |-> (gap_q >= 32'(MIN_PERIOD - 1)));

endmodule

bind burst_trig_gen burst_trig_gen_chk #(.MIN_PERIOD(MIN_PERIOD)) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .start_i (start_i),
    .trig_o  (trig_o),
    .busy_o  (busy_o)
);

// File: tb/burst_trig_gen_tb_top.sv
module burst_trig_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        cont = 1'b0;
    logic        start = 1'b0;
    logic [31:0] period = 32'd10;
    logic [31:0] blen = 32'd1;
    logic [31:0] fdel = 32'd0;
    logic        trig, busy;

    int    cyc = 0;
    int    n_checks = 0;
    int    n_fail = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    prev_trig = 1'b0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    burst_trig_gen dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .enable_i     (enable),
        .cont_mode_i  (cont),
        .start_i      (start),
        .period_i     (period),
        .burst_len_i  (blen),
        .first_delay_i(fdel),
        .trig_o       (trig),
        .busy_o       (busy)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Monitor: pops the scoreboard on each observed trigger.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (trig) begin
                check(!prev_trig, "R3 pulse width", 2, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected trigger", cyc, -1);
                end else begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(cyc == e, t, cyc, e);
                end
            end
            prev_trig = trig;
        end
    end

    // Driver: pulses start and pushes the expected trigger cycles.
    task automatic launch(input bit c, input int d, input int p, input int n,
                          input int npush, input string tag, output int s);
        int peff;
        peff = (p < 10) ? 10 : p;
        @(negedge clk);
        cont   = c;
        fdel   = 32'(d);
        period = 32'(p);
        blen   = 32'(n);
        start  = 1'b1;
        s = cyc + 1;
        for (int i = 0; i < npush; i++) begin
            exp_q.push_back(s + d + 1 + i * peff);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    endtask

    task automatic wait_cyc(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic wait_idle(input string tag);
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
        check(busy == 1'b0, tag, int'(busy), 0);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int s;
        repeat (3) @(negedge clk);
        check(trig == 1'b0, "R1 trig in reset", int'(trig), 0);
        check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);

        // R4: burst of three, busy falls the edge after the last trigger
        launch(1'b0, 5, 10, 3, 3, "R4 burst timing", s);
        wait_cyc(s + 26);
        check(busy == 1'b1, "R4 busy at last trigger", int'(busy), 1);
        @(negedge clk);
        check(busy == 1'b0, "R4 busy after last trigger", int'(busy), 0);
        wait_idle("R4 burst end");

        // R2: zero start delay
        launch(1'b0, 0, 25, 2, 2, "R2 zero delay", s);
        wait_idle("R2 end");

        // R5: zero length gives one trigger
        launch(1'b0, 2, 15, 0, 1, "R5 zero length", s);
        wait_idle("R5 end");
        repeat (20) @(negedge clk);

        // R6: period below minimum
        launch(1'b0, 1, 3, 3, 3, "R6 clamped period", s);
        wait_idle("R6 end");

        // R9 and R11: restart strobe and config changes mid-burst
        launch(1'b0, 4, 20, 3, 3, "R11 captured config", s);
        repeat (10) @(negedge clk);
        period = 32'd50;
        fdel   = 32'd0;
        blen   = 32'd9;
        cont   = 1'b1;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle("R9 restart ignored");
        cont = 1'b0;

        // R10: start while disabled
        enable = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R10 start while disabled", int'(busy), 0);
        repeat (40) @(negedge clk);
        check(busy == 1'b0, "R10 still idle", int'(busy), 0);
        enable = 1'b1;

        // R7 and R8: continuous run, length ignored, then abort
        launch(1'b1, 3, 12, 2, 5, "R7 continuous", s);
        wait_cyc(s + 52);
        enable = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R8 abort continuous", int'(busy), 0);
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R7 all triggers seen", exp_q.size(), 0);
        enable = 1'b1;

        // R8: abort during the start delay
        launch(1'b0, 100, 10, 2, 0, "R8 abort in delay", s);
        wait_cyc(s + 10);
        enable = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R8 abort in delay", int'(busy), 0);
        repeat (120) @(negedge clk);
        enable = 1'b1;

        // R7: continuous at the minimum period
        launch(1'b1, 0, 10, 0, 3, "R7 continuous min period", s);
        wait_cyc(s + 21);
        enable = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R8 abort at min period", int'(busy), 0);
        repeat (30) @(negedge clk);
        check(exp_q.size() == 0, "R7 min period all seen", exp_q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule